// File: doc/BRIEF.md
# SDI Sync-Bit Inserter

This block sits in the transmit path of a serial digital video link, directly ahead of the scrambler. It receives a 10-bit parallel word stream, one word per cycle in which the input valid is high. At the two highest link rates it looks for groups of back-to-back all-ones (3FFh) and all-zeros (000h) words. It rewrites the two low bits of those words with a fixed alternating pattern. Without this, the scrambler polynomial could be fed hundreds of identical bits in a row, which is the source of pathological line patterns.

The receiver still needs one genuine word-alignment preamble. For that reason, the last all-ones word and the two all-zeros words that close a group just before ordinary data are passed untouched when they form the exact sequence 3FFh, 000h, 000h. An isolated 3FFh or 000h word that has ordinary data on both sides is also left alone. At every other rate the stream passes through bit-exact.

The block decides each word by looking three words ahead and two words back. Output therefore trails input by a fixed three accepted words. Input stalls, meaning cycles with the valid low, freeze the whole pipeline.

Top module: `sdi_sync_insert`

## Requirements
- R1: When a word's rate code is not 3 (6G) or 4 (12G), that word leaves the block unchanged. Rate codes 0 to 2 and 5 to 7 are all pass-through, and the rate code travels with its word.
- R2: At rates 3/4, a 000h word that belongs to a group of two or more consecutive words, each 000h or 3FFh, is emitted as 002h (low bits replaced by 10b), unless R4 keeps it.
- R3: At rates 3/4, a 3FFh word in such a group is emitted as 3FDh (low bits replaced by 01b), unless R4 keeps it.
- R4: When a group ends with 3FFh, 000h, 000h immediately before a word that is neither 3FFh nor 000h, those three words are emitted unmodified.
- R5: A 3FFh or 000h word whose previous and next words are both neither 3FFh nor 000h is emitted unmodified. A word accepted directly after reset has no previous word and counts as having ordinary data before it.
- R6: Any word other than 3FFh and 000h is emitted unchanged at every rate.
- R7: The n-th accepted word appears on the output, with the output valid high, in the clock cycle that follows the acceptance of word n+3. The output valid is high only in cycles that follow an accepted input.
- R8: Synchronous reset clears the pipeline: the output valid is low with data 000h, and no word from before reset influences any later decision.
- R9: Cycles with the input valid low do not advance the pipeline, and the data present in those cycles is ignored. Results do not depend on where stalls fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input word strobe; low means stall |
| inData | input | 10 | Input video word |
| inRate | input | 3 | Rate code of the input word (3 = 6G, 4 = 12G) |
| outValid | output | 1 | Output word strobe |
| outData | output | 10 | Output video word, low bits possibly rewritten |

## Verification
The hardest situation to reach from the ports is the closing preamble combined with the boundaries around it. Examples are a group that ends with only 000h, 000h, a preamble preceded by a long all-zeros run, a two-word group with no preamble, and a preamble that is itself the whole group. Random stimulus seldom produces these shapes in the right order, so the stimulus is built from run generators. Each generator emits a group of random length and mix, optionally closes it with the exact preamble, and always terminates it with an ordinary word. Directed sequences are added for the short boundary shapes and for a run of several hundred zeros. Random stalls that carry special words on the idle bus are mixed in, together with per-segment rate changes.

// File: rtl/sdi_sync_pkg.sv
package sdi_sync_pkg;

  localparam int RATE_W = 3;

  typedef enum logic [RATE_W-1:0] {
    RATE_SD  = 3'd0,
    RATE_HD  = 3'd1,
    RATE_3G  = 3'd2,
    RATE_6G  = 3'd3,
    RATE_12G = 3'd4
  } rate_e;

  // Decision strobes from control to datapath for the word leaving the window
  typedef struct packed {
    logic rewrite;      // replace low bits of the outgoing word
    logic keepPreamble; // word belongs to the closing preamble
    logic keepAlone;    // isolated special word
  } sync_strobe_t;

  function automatic logic rateNeedsSync(input logic [RATE_W-1:0] rate);
    return (rate == RATE_6G) || (rate == RATE_12G);
  endfunction

endpackage

// File: rtl/sdi_sync_ctrl.sv
module sdi_sync_ctrl
  import sdi_sync_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  // look-back taps (already emitted raw words)
  input  logic [WORD_W-1:0] back1Data,
  input  logic              back1Vld,
  input  logic [WORD_W-1:0] back2Data,
  input  logic              back2Vld,
  // current outgoing word and its rate
  input  logic [WORD_W-1:0] curData,
  input  logic              curVld,
  input  logic [RATE_W-1:0] curRate,
  // look-ahead taps, nearest first; the last one is the incoming word
  input  logic [WORD_W-1:0] ahead1Data,
  input  logic              ahead1Vld,
  input  logic [WORD_W-1:0] ahead2Data,
  input  logic              ahead2Vld,
  input  logic [WORD_W-1:0] ahead3Data,
  output sync_strobe_t      strobe
);

  localparam logic [WORD_W-1:0] ONES  = '1;
  localparam logic [WORD_W-1:0] ZEROS = '0;

  function automatic logic isSpecial(input logic [WORD_W-1:0] d, input logic v);
    return v && ((d == ONES) || (d == ZEROS));
  endfunction

  logic back1Sp, ahead1Sp, ahead2Sp, ahead3Sp, curSp;
  logic preFirst, preSecond, preThird, alone;

  always_comb begin
    curSp    = isSpecial(curData, curVld);
    back1Sp  = isSpecial(back1Data, back1Vld);
    ahead1Sp = isSpecial(ahead1Data, ahead1Vld);
    ahead2Sp = isSpecial(ahead2Data, ahead2Vld);
    ahead3Sp = isSpecial(ahead3Data, advance);

    // Closing preamble: 3FF 000 000 followed by ordinary data
    preFirst  = (curData == ONES) && ahead1Vld && (ahead1Data == ZEROS)
              && ahead2Vld && (ahead2Data == ZEROS) && !ahead3Sp;
    preSecond = (curData == ZEROS) && back1Vld && (back1Data == ONES)
              && ahead1Vld && (ahead1Data == ZEROS) && !ahead2Sp;
    preThird  = (curData == ZEROS) && back1Vld && (back1Data == ZEROS)
              && back2Vld && (back2Data == ONES) && !ahead1Sp;
    alone     = !back1Sp && !ahead1Sp;

    strobe.keepPreamble = curSp && (preFirst || preSecond || preThird);
    strobe.keepAlone    = curSp && alone;
    strobe.rewrite      = curSp && rateNeedsSync(curRate)
                        && !strobe.keepPreamble && !strobe.keepAlone;
  end

  // R4: a word takes at most one preamble position, and never also counts as isolated
  p_keep_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    advance |-> $onehot0({preFirst && curSp, preSecond && curSp, preThird && curSp, strobe.keepAlone}));

  // R1: no rewrite is requested for a word at a low rate
  p_rate_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (advance && !rateNeedsSync(curRate)) |-> !strobe.rewrite);

endmodule

// File: rtl/sdi_sync_window.sv
module sdi_sync_window
  import sdi_sync_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int AHEAD  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  input  logic [RATE_W-1:0] inRate,
  input  sync_strobe_t      strobe,
  // taps for the control
  output logic [WORD_W-1:0] back1Data,
  output logic              back1Vld,
  output logic [WORD_W-1:0] back2Data,
  output logic              back2Vld,
  output logic [WORD_W-1:0] stData  [AHEAD],
  output logic              stVld   [AHEAD],
  output logic [RATE_W-1:0] curRate,
  output logic              outValid,
  output logic [WORD_W-1:0] outData
);

  localparam int LAST = AHEAD - 1;
  localparam logic [1:0] LOW_FOR_ZEROS = 2'b10;
  localparam logic [1:0] LOW_FOR_ONES  = 2'b01;
  localparam logic [WORD_W-1:0] ONES  = '1;
  localparam logic [WORD_W-1:0] ZEROS = '0;

  logic [RATE_W-1:0] stRate [AHEAD];
  logic [WORD_W-1:0] outRaw;
  logic [RATE_W-1:0] outRate;
  logic [WORD_W-1:0] rewritten;

  always_comb begin
    rewritten = stData[LAST];
    rewritten[1:0] = (stData[LAST] == ZEROS) ? LOW_FOR_ZEROS : LOW_FOR_ONES;
  end

  // Stage 0 takes the incoming word; later stages shift in generate
  always_ff @(posedge clk) begin
    if (rst) begin
      stData[0] <= '0;
      stVld[0]  <= 1'b0;
      stRate[0] <= '0;
    end else if (inValid) begin
      stData[0] <= inData;
      stVld[0]  <= 1'b1;
      stRate[0] <= inRate;
    end
  end

  for (genvar g = 1; g < AHEAD; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stData[g] <= '0;
        stVld[g]  <= 1'b0;
        stRate[g] <= '0;
      end else if (inValid) begin
        stData[g] <= stData[g-1];
        stVld[g]  <= stVld[g-1];
        stRate[g] <= stRate[g-1];
      end
    end
  end

  assign curRate = stRate[LAST];

  always_ff @(posedge clk) begin
    if (rst) begin
      back1Data <= '0;
      back1Vld  <= 1'b0;
      back2Data <= '0;
      back2Vld  <= 1'b0;
      outValid  <= 1'b0;
      outData   <= '0;
      outRaw    <= '0;
      outRate   <= '0;
    end else if (inValid) begin
      back1Data <= stData[LAST];
      back1Vld  <= stVld[LAST];
      back2Data <= back1Data;
      back2Vld  <= back1Vld;
      outValid  <= stVld[LAST];
      outRaw    <= stData[LAST];
      outRate   <= stRate[LAST];
      outData   <= strobe.rewrite ? rewritten : stData[LAST];
    end else begin
      outValid  <= 1'b0;
    end
  end

  // R2/R3: any change to a word is one of the two sync substitutions
  p_legal_rewrite_r2: assert property (@(posedge clk) disable iff (rst)
    (outValid && (outData != outRaw)) |->
      ((outRaw == ZEROS && outData == {{(WORD_W-2){1'b0}}, LOW_FOR_ZEROS}) ||
       (outRaw == ONES  && outData == {{(WORD_W-2){1'b1}}, LOW_FOR_ONES})));

  // R1: low-rate words leave unchanged
  p_low_rate_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (outValid && !rateNeedsSync(outRate)) |-> (outData == outRaw));

  // R9: no output strobe follows a stalled cycle
  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R8: first cycle after reset shows an empty output
  p_reset_clear_r8: assert property (@(posedge clk)
    $past(rst) |-> (!outValid && outData == '0));

endmodule

// File: rtl/sdi_sync_insert.sv
module sdi_sync_insert
  import sdi_sync_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inData,
  input  logic [2:0]        inRate,
  output logic              outValid,
  output logic [WORD_W-1:0] outData
);

  localparam int AHEAD = 3;

  sync_strobe_t      strobe;
  logic [WORD_W-1:0] back1Data, back2Data;
  logic              back1Vld, back2Vld;
  logic [WORD_W-1:0] stData [AHEAD];
  logic              stVld  [AHEAD];
  logic [RATE_W-1:0] curRate;

  sdi_sync_window #(.WORD_W(WORD_W), .AHEAD(AHEAD)) u_window (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .inData    (inData),
    .inRate    (inRate),
    .strobe    (strobe),
    .back1Data (back1Data),
    .back1Vld  (back1Vld),
    .back2Data (back2Data),
    .back2Vld  (back2Vld),
    .stData    (stData),
    .stVld     (stVld),
    .curRate   (curRate),
    .outValid  (outValid),
    .outData   (outData)
  );

  sdi_sync_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .advance    (inValid),
    .back1Data  (back1Data),
    .back1Vld   (back1Vld),
    .back2Data  (back2Data),
    .back2Vld   (back2Vld),
    .curData    (stData[2]),
    .curVld     (stVld[2]),
    .curRate    (curRate),
    .ahead1Data (stData[1]),
    .ahead1Vld  (stVld[1]),
    .ahead2Data (stData[0]),
    .ahead2Vld  (stVld[0]),
    .ahead3Data (inData),
    .strobe     (strobe)
  );

endmodule

// File: tb/sdi_sync_insert_tb.sv
module sdi_sync_insert_tb;

  localparam int NW = 8000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [9:0] inData = '0;
  logic [2:0] inRate = '0;
  logic       outValid;
  logic [9:0] outData;

  always #2 clk = ~clk;

  sdi_sync_insert u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .inRate(inRate), .outValid(outValid), .outData(outData)
  );

  logic [9:0] wd [NW];
  logic [2:0] wr [NW];
  int nIn = 0, inCnt = 0, outCnt = 0;
  int checks = 0, fails = 0;
  logic monOn = 1'b0;

  task automatic push(input logic [9:0] d, input logic [2:0] r);
    if (nIn < NW) begin wd[nIn] = d; wr[nIn] = r; nIn++; end
  endtask

  function automatic logic [9:0] plainWord();
    return 10'($urandom % 1022 + 1);
  endfunction

  function automatic logic [9:0] val(input int i);
    if (i < 0 || i >= nIn) return 10'h155;
    return wd[i];
  endfunction

  function automatic logic sp(input int i);
    return val(i) == 10'h000 || val(i) == 10'h3FF;
  endfunction

  // kind: 0 plain(R6) 1 low rate(R1) 2 preamble(R4) 3 alone(R5) 4 rewritten 000(R2) 5 rewritten 3FF(R3)
  function automatic int kindOf(input int i);
    logic hi, p0, p1, p2;
    hi = (wr[i] == 3'd3) || (wr[i] == 3'd4);
    if (!sp(i)) return 0;
    if (!hi) return 1;
    p0 = val(i) == 10'h3FF && val(i+1) == 0 && val(i+2) == 0 && !sp(i+3);
    p1 = val(i) == 0 && val(i-1) == 10'h3FF && val(i+1) == 0 && !sp(i+2);
    p2 = val(i) == 0 && val(i-1) == 0 && val(i-2) == 10'h3FF && !sp(i+1);
    if (p0 || p1 || p2) return 2;
    if (!sp(i-1) && !sp(i+1)) return 3;
    return (val(i) == 0) ? 4 : 5;
  endfunction

  function automatic logic [9:0] expOut(input int i);
    case (kindOf(i))
      4: return 10'h002;
      5: return 10'h3FD;
      default: return wd[i];
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic buildStimulus();
    logic [2:0] r;
    // directed: alone word first after reset (R5, R8)
    push(10'h000, 3'd3); push(10'h111, 3'd3);
    push(10'h3FF, 3'd4); push(10'h000, 3'd4); push(10'h000, 3'd4); push(10'h200, 3'd4);
    push(10'h000, 3'd3); push(10'h000, 3'd3); push(10'h123, 3'd3);
    push(10'h3FF, 3'd3); push(10'h3FF, 3'd3); push(10'h0AA, 3'd3);
    push(10'h000, 3'd4); push(10'h3FF, 3'd4); push(10'h000, 3'd4); push(10'h000, 3'd4); push(10'h301, 3'd4);
    push(10'h3FF, 3'd3); push(10'h000, 3'd3); push(10'h1F0, 3'd3);
    push(10'h3FF, 3'd1); push(10'h3FF, 3'd1); push(10'h000, 3'd1); push(10'h004, 3'd1);
    for (int k = 0; k < 300; k++) push(10'h000, 3'd4);
    push(10'h3FF, 3'd4); push(10'h000, 3'd4); push(10'h000, 3'd4); push(10'h155, 3'd4);
    while (nIn < NW - 460) begin
      r = ($urandom % 3 != 0) ? 3'(3 + $urandom % 2) : 3'($urandom % 8);
      case ($urandom % 6)
        0: for (int k = 0; k < 1 + $urandom % 5; k++) push(plainWord(), r);
        1: begin
             for (int k = 0; k < 150 + $urandom % 250; k++) push(($urandom % 9 == 0) ? 10'h3FF : 10'h000, r);
             if ($urandom % 2) begin push(10'h3FF, r); push(10'h000, r); push(10'h000, r); end
           end
        default: begin
             for (int k = 0; k < 1 + $urandom % 12; k++) push(($urandom % 2) ? 10'h3FF : 10'h000, r);
             if ($urandom % 2) begin push(10'h3FF, r); push(10'h000, r); push(10'h000, r); end
           end
      endcase
      push(plainWord(), r);
    end
    for (int k = 0; k < 4; k++) push(plainWord(), 3'd3);
  endtask

  // Driver
  initial begin
    void'($urandom(32'd20240611));
    buildStimulus();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check(!outValid && outData == 10'h000, "R8 reset state", {outValid, outData}, 0);
    monOn = 1'b1;
    for (int i = 0; i < nIn; i++) begin
      while ($urandom % 4 == 0) begin
        @(negedge clk);
        inValid = 1'b0;
        inData  = ($urandom % 2) ? 10'h000 : 10'h3FF;
        inRate  = 3'($urandom % 8);
      end
      @(negedge clk);
      inValid = 1'b1; inData = wd[i]; inRate = wr[i];
      inCnt++;
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (6) @(negedge clk);
    check(outCnt == nIn - 3, "R7 output count", outCnt, nIn - 3);
    summary();
  end

  // Monitor
  initial begin
    string req;
    forever begin
      @(posedge clk); #1;
      if (monOn) begin
        if (!inValid) begin
          if (outValid) check(1'b0, "R9 output strobe after stall", 1, 0);
        end else if (inCnt >= 4) begin
          check(outValid, "R7 output strobe", outValid, 1);
        end
        if (outValid) begin
          check(inCnt == outCnt + 4, "R7 latency", inCnt, outCnt + 4);
          case (kindOf(outCnt))
            0: req = "R6 plain word";
            1: req = "R1 low rate";
            2: req = "R4 closing preamble";
            3: req = "R5 isolated word";
            4: req = "R2 zeros rewrite";
            default: req = "R3 ones rewrite";
          endcase
          check(outData == expOut(outCnt), req, outData, expOut(outCnt));
          outCnt++;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", outCnt, nIn - 3);
    summary();
  end

endmodule